// File: doc/BRIEF.md
# Boundary-Scan Data Register with Inverted Input Capture

This block is a chain of boundary-scan cells that sits between a core and its pins. It has `N_IN` cells on the core's input side and `N_OUT` cells on the output side. Each cell has a capture/shift flip-flop that forms one stage of a serial path from `tdi_i` to `tdo_o`. Each cell also has an update latch that holds the data the cell applies in test mode. A TAP controller and an instruction decoder outside the block supply the strobes for the capture, shift and update states. They also supply a select line and a test-mode line.

Outside test mode the cells are transparent. In test mode the update latches drive the core inputs and the output pins. When a capture happens in test mode, an input cell stores the complement of the value it is currently driving into the core. An output cell always stores the true core output. The core can be single-stepped by repeating capture, shift and update. A pattern can be loaded while the block is outside test mode, and that pattern takes effect at the moment test mode is switched on.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_ni` is low, every capture/shift flip-flop and every update latch is cleared. As a result `tdo_o` is 0, and in test mode `core_in_o` and `pin_out_o` are all zero.
- R2: With `test_mode_i` low, `core_in_o` equals `pin_in_i` and `pin_out_o` equals `core_out_i`, whatever the latches hold.
- R3: With `test_mode_i` high, `core_in_o[k]` is the update latch of input cell k and `pin_out_o[j]` is the update latch of output cell j.
- R4: On a rising `tck_i` edge with `chain_sel_i` and `capture_dr_i` high and `test_mode_i` high, each input cell stores the inverse of the value it drives on `core_in_o`.
- R5: On a capture edge, in either mode, each output cell stores the true value of `core_out_i`.
- R6: On a capture edge with `test_mode_i` low, each input cell stores the true value of `pin_in_i`.
- R7: Chain order runs from `tdi_i` through input cells 0 to `N_IN-1`, then output cells 0 to `N_OUT-1`, to `tdo_o`. The length is `N_IN+N_OUT`. Each rising edge with `chain_sel_i` and `shift_dr_i` high moves the data one stage toward `tdo_o`. `tdo_o` shows the last stage, so after a capture the first bit out is output cell `N_OUT-1` and the last bit out is input cell 0. At most one of the three strobes is high in any cycle.
- R8: On a falling `tck_i` edge with `chain_sel_i` and `update_dr_i` high, every update latch loads its cell's shift stage, and test-mode outputs change at that edge. At every other time the latches hold, including during shifting.
- R9: With `chain_sel_i` low, the strobes have no effect: the shift stages, the latches, `tdo_o` and the test-mode outputs are unchanged.
- R10: Latches that were loaded while `test_mode_i` was low appear on `core_in_o` and `pin_out_o` as soon as `test_mode_i` rises, with no further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_sel_i | input | 1 | This register is the selected data register |
| capture_dr_i | input | 1 | Capture state strobe |
| shift_dr_i | input | 1 | Shift state strobe |
| update_dr_i | input | 1 | Update state strobe |
| test_mode_i | input | 1 | Internal test mode active |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| pin_in_i | input | N_IN | Values from the input pins |
| core_in_o | output | N_IN | Values to the core inputs |
| core_out_i | input | N_OUT | Values from the core outputs |
| pin_out_o | output | N_OUT | Values to the output pins |

## Verification
The assertions check the following properties on every edge, for each cell:
- the capture source that the mode selects, including the inverted value on input cells in test mode;
- the one-stage serial move on each shift edge;
- that a cell holds when no strobe is active;
- the falling-edge latch copy and the hold of the latches between updates;
- that the strobes are mutually exclusive and that `tdo_o` is quiet while the chain is deselected.

Some behaviour involves the whole chain and shows only in the bench's scenarios:
- the bit order at `tdo_o` after a capture;
- the mapping of a shifted pattern onto the core-input and pin outputs;
- the output change in the middle of the cycle on an update;
- a preloaded pattern appearing the instant test mode is entered;
- the round trip of a single-step sequence.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {OP_HOLD, OP_CAPTURE, OP_SHIFT} cell_op_e;
  typedef enum logic {CELL_IN, CELL_OUT} cell_kind_e;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  logic     chain_sel_i,
  input  logic     capture_dr_i,
  input  logic     shift_dr_i,
  input  logic     update_dr_i,
  output cell_op_e op_o,
  output logic     upd_en_o
);
  always_comb begin
    op_o = OP_HOLD;
    if (chain_sel_i && capture_dr_i)    op_o = OP_CAPTURE;
    else if (chain_sel_i && shift_dr_i) op_o = OP_SHIFT;
  end

  assign upd_en_o = chain_sel_i && update_dr_i;

  // R7: the TAP drives at most one of the three state strobes
  a_r7_strobes_exclusive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({capture_dr_i, shift_dr_i, update_dr_i}));
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_IN
) (
  input  logic     tck_i,
  input  logic     rst_ni,
  input  cell_op_e op_i,
  input  logic     upd_en_i,
  input  logic     test_mode_i,
  input  logic     si_i,
  input  logic     func_i,
  output logic     so_o,
  output logic     data_o
);
  logic cap_q, cap_d, par_q, capt_val;

  generate
    if (KIND == CELL_IN) begin : g_in
      // inverted sample of the driven value in test mode
      assign capt_val = test_mode_i ? ~par_q : func_i;
    end else begin : g_out
      assign capt_val = func_i;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_CAPTURE: cap_d = capt_val;
      OP_SHIFT:   cap_d = si_i;
      default:    cap_d = cap_q;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_d;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       par_q <= 1'b0;
    else if (upd_en_i) par_q <= cap_q;
  end

  assign so_o   = cap_q;
  assign data_o = test_mode_i ? par_q : func_i;

  generate
    if (KIND == CELL_IN) begin : g_in_chk
      a_r4_inverted_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (op_i == OP_CAPTURE && test_mode_i) |=> (so_o == ~$past(data_o)));
      a_r6_true_pin_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (op_i == OP_CAPTURE && !test_mode_i) |=> (so_o == $past(func_i)));
    end else begin : g_out_chk
      a_r5_true_core_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (op_i == OP_CAPTURE) |=> (so_o == $past(func_i)));
    end
  endgenerate

  a_r7_shift_one_stage: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (so_o == $past(si_i)));
  a_r9_hold_stage: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(so_o));
  a_r8_update_copy: assert property (@(negedge tck_i) disable iff (!rst_ni)
    upd_en_i |=> (par_q == $past(so_o)));
  a_r8_latch_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(par_q));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             chain_sel_i,
  input  logic             capture_dr_i,
  input  logic             shift_dr_i,
  input  logic             update_dr_i,
  input  logic             test_mode_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pin_out_o
);
  localparam int LEN = N_IN + N_OUT;

  cell_op_e       op;
  logic           upd_en;
  logic [LEN:0]   ser;

  bscan_ctrl i_ctrl (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .chain_sel_i  (chain_sel_i),
    .capture_dr_i (capture_dr_i),
    .shift_dr_i   (shift_dr_i),
    .update_dr_i  (update_dr_i),
    .op_o         (op),
    .upd_en_o     (upd_en)
  );

  assign ser[0] = tdi_i;

  // input cells nearest tdi
  for (genvar k = 0; k < N_IN; k++) begin : g_in_cell
    bscan_cell #(.KIND(CELL_IN)) i_cell (
      .tck_i       (tck_i),
      .rst_ni      (rst_ni),
      .op_i        (op),
      .upd_en_i    (upd_en),
      .test_mode_i (test_mode_i),
      .si_i        (ser[k]),
      .func_i      (pin_in_i[k]),
      .so_o        (ser[k+1]),
      .data_o      (core_in_o[k])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
    bscan_cell #(.KIND(CELL_OUT)) i_cell (
      .tck_i       (tck_i),
      .rst_ni      (rst_ni),
      .op_i        (op),
      .upd_en_i    (upd_en),
      .test_mode_i (test_mode_i),
      .si_i        (ser[N_IN+j]),
      .func_i      (core_out_i[j]),
      .so_o        (ser[N_IN+j+1]),
      .data_o      (pin_out_o[j])
    );
  end

  assign tdo_o = ser[LEN];

  a_r9_tdo_quiet_deselected: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !chain_sel_i |=> $stable(tdo_o));
  a_r8_outputs_stable_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_dr_i && test_mode_i && $past(test_mode_i) && $past(shift_dr_i))
      |-> ($stable(core_in_o) && $stable(pin_out_o)));
endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int N_IN = 4;
  localparam int N_OUT = 3;
  localparam int LEN = N_IN + N_OUT;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic             tm;
    logic [N_IN-1:0]  pins;
    logic [N_OUT-1:0] core;
    logic [LEN-1:0]   din;
  } vec_t;

  localparam vec_t VECS[7] = '{
    '{1'b0, 4'b1010, 3'b011, 7'b1100101},
    '{1'b0, 4'b0110, 3'b100, 7'b0011010},
    '{1'b1, 4'b0000, 3'b101, 7'b1111000},
    '{1'b1, 4'b1111, 3'b010, 7'b0101011},
    '{1'b1, 4'b0101, 3'b111, 7'b0000000},
    '{1'b1, 4'b1001, 3'b000, 7'b1111111},
    '{1'b0, 4'b1111, 3'b110, 7'b1010101}
  };

  logic tck_i = 1'b0, rst_ni = 1'b0;
  logic chain_sel_i = 1'b1, capture_dr_i = 1'b0, shift_dr_i = 1'b0, update_dr_i = 1'b0;
  logic test_mode_i = 1'b1, tdi_i = 1'b0, tdo_o;
  logic [N_IN-1:0]  pin_in_i = '0, core_in_o;
  logic [N_OUT-1:0] core_out_i = '0, pin_out_o;

  int checks = 0, fails = 0;
  logic [LEN-1:0] lat = '0;   // bench model of update latches, by chain position
  logic [LEN-1:0] dout, capv;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) i_bscan_chain (.*);

  always #(CLK_PERIOD/2) tck_i = ~tck_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge tck_i); #1;
  endtask

  task automatic check_outs(input string req);
    if (test_mode_i) begin
      check(req, 32'(core_in_o), 32'(lat[N_IN-1:0]));
      check(req, 32'(pin_out_o), 32'(lat[LEN-1:N_IN]));
    end else begin
      check(req, 32'(core_in_o), 32'(pin_in_i));
      check(req, 32'(pin_out_o), 32'(core_out_i));
    end
  endtask

  task automatic do_shift(input logic [LEN-1:0] din, output logic [LEN-1:0] d_o);
    shift_dr_i = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      tdi_i = din[i];
      d_o[i] = tdo_o;
      clk1();
    end
    shift_dr_i = 1'b0;
  endtask

  function automatic logic [LEN-1:0] placed(input logic [LEN-1:0] din);
    logic [LEN-1:0] r;
    for (int p = 0; p < LEN; p++) r[p] = din[LEN-1-p];
    return r;
  endfunction

  task automatic do_update(input logic [LEN-1:0] din);
    update_dr_i = 1'b1;
    clk1();
    update_dr_i = 1'b0;
    lat = placed(din);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    check("R1 tdo", 32'(tdo_o), 0);
    check_outs("R1");
    #(CLK_PERIOD/2);
    rst_ni = 1'b1;
    clk1();

    // table walk: R2..R7 single-step loop
    foreach (VECS[v]) begin
      test_mode_i = VECS[v].tm;
      pin_in_i    = VECS[v].pins;
      core_out_i  = VECS[v].core;
      #1;
      check_outs(VECS[v].tm ? "R3" : "R2");
      for (int p = 0; p < LEN; p++)
        capv[p] = (p < N_IN) ? (VECS[v].tm ? ~lat[p] : pin_in_i[p]) : core_out_i[p-N_IN];
      capture_dr_i = 1'b1;
      clk1();
      capture_dr_i = 1'b0;
      do_shift(VECS[v].din, dout);
      check(VECS[v].tm ? "R4/R5/R7 capture" : "R6/R5/R7 capture", 32'(dout), 32'(placed(capv)));
      do_update(VECS[v].din);
      check_outs(VECS[v].tm ? "R3/R8" : "R2");
    end

    // R9 deselected strobes ignored
    test_mode_i = 1'b1;
    #1;
    chain_sel_i = 1'b0;
    tdi_i = 1'b1;
    capture_dr_i = 1'b1; clk1(); capture_dr_i = 1'b0;
    shift_dr_i = 1'b1; clk1(); clk1(); shift_dr_i = 1'b0;
    check("R9 tdo", 32'(tdo_o), 32'(VECS[6].din[LEN-1]));
    update_dr_i = 1'b1; clk1(); update_dr_i = 1'b0;
    check_outs("R9");
    chain_sel_i = 1'b1;
    do_shift('0, dout);
    check("R9 contents", 32'(dout), 32'(VECS[6].din));

    // R8 latches hold mid-shift, load on falling edge
    shift_dr_i = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      tdi_i = 7'b0110011 >> i;
      clk1();
      if (i == 3) check_outs("R8 hold");
    end
    shift_dr_i = 1'b0;
    update_dr_i = 1'b1;
    @(negedge tck_i); #1;
    lat = placed(7'b0110011);
    check_outs("R8 falling edge");
    @(posedge tck_i); #1;
    update_dr_i = 1'b0;

    // R10 preload then enter test mode
    test_mode_i = 1'b0;
    pin_in_i = 4'b1100;
    core_out_i = 3'b001;
    do_shift(7'b1001110, dout);
    do_update(7'b1001110);
    #1;
    check_outs("R10 transparent");
    test_mode_i = 1'b1;
    #1;
    check_outs("R10 applied");

    // R1 async reset mid-run
    rst_ni = 1'b0;
    #1;
    lat = '0;
    check("R1 tdo", 32'(tdo_o), 0);
    check_outs("R1 async");
    clk1();
    rst_ni = 1'b1;
    clk1();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule